// File: doc/BRIEF.md
# UART DMA and Interrupt Request Generator

This block sits beside a UART core and turns the core's buffer and error flags into service requests for the rest of the chip. It has one DMA request line for the transmit side and one for the receive side, plus one combined, active-high interrupt line. A DMA request is raised only when a buffer flag goes from clear to set while that side's DMA enable is on. The request then holds until the DMA controller returns a one-cycle acknowledge.

Each side has its own DMA enable, and both may be on together for full-duplex transfers that need no processor. When a side's DMA enable is on, that side's buffer interrupt is suppressed whatever its interrupt enable says. The receive error interrupt is not affected by the DMA enables, so receive faults are still reported while DMA moves the data.

Reset is synchronous and active low. During reset the stored copies of the buffer flags follow the live flags, so a flag that is already set when reset ends does not look like a new edge.

Top module: `uart_req_ctrl`

## Requirements
- R1: With `txDmaEn` high, a low-to-high change of `txEmpty` seen at a clock edge sets `txDmaReq` high from that edge on. The request is visible one cycle after the flag rises.
- R2: With `rxDmaEn` high, a low-to-high change of `rxFull` seen at a clock edge sets `rxDmaReq` high from that edge on. The request is visible one cycle after the flag rises.
- R3: No request is raised while a flag stays set, including the case where DMA is enabled after the flag is already high. No request is raised for a rising flag while that side's DMA enable is low.
- R4: A raised request stays high until an acknowledge (`txDmaAck` / `rxDmaAck`) is seen at a clock edge, and is low from that edge on.
- R5: If an acknowledge and a new qualifying flag edge meet at the same clock edge, the request stays high. An acknowledge while the request is low has no effect.
- R6: While `txDmaEn` is high, `txEmpty` does not contribute to `irqOut`, whatever the value of `txIrqEn`.
- R7: While `rxDmaEn` is high, `rxFull` does not contribute to `irqOut`, whatever the value of `rxIrqEn`.
- R8: Any set bit of `rxErr` with `errIrqEn` high drives `irqOut` high, whatever the DMA enables are.
- R9: `irqOut` is a register that holds the OR of the unmasked transmit (`txEmpty & txIrqEn`), receive (`rxFull & rxIrqEn`) and error sources sampled at the previous clock edge. It is low when no source is active.
- R10: After a clock edge with `rst_n` low, both requests and `irqOut` are low. A flag that is set during reset and stays set raises no request after reset ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| txEmpty | input | 1 | Transmit buffer empty flag from the UART core |
| rxFull | input | 1 | Receive buffer full flag from the UART core |
| rxErr | input | ERR_W | Receive error flags (framing, parity, overrun, ...) |
| txDmaEn | input | 1 | Transmit DMA enable |
| rxDmaEn | input | 1 | Receive DMA enable |
| txIrqEn | input | 1 | Transmit interrupt enable |
| rxIrqEn | input | 1 | Receive interrupt enable |
| errIrqEn | input | 1 | Receive error interrupt enable |
| txDmaAck | input | 1 | One-cycle acknowledge for the transmit request |
| rxDmaAck | input | 1 | One-cycle acknowledge for the receive request |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| irqOut | output | 1 | Combined interrupt, active high |

## Verification
A request can be cleared by an acknowledge in the same cycle that a new flag edge tries to set it. The bench provokes this by dropping and raising `txEmpty` while a transmit request is still pending, and pulsing `txDmaAck` on the edge where the flag rises. The request must stay high through that edge and fall only at a later acknowledge that has no edge beside it. Both flags are also raised together, and acknowledged together, to show that the two channels set and clear independently in the same cycle.

// File: rtl/uart_req_pkg.sv
package uart_req_pkg;
  localparam int CH_NUM = 2;
  localparam int CH_TX  = 0;
  localparam int CH_RX  = 1;
  localparam int SRC_NUM = CH_NUM + 1;

  typedef struct packed {
    logic [CH_NUM-1:0]  setReq;
    logic [CH_NUM-1:0]  clrReq;
    logic [SRC_NUM-1:0] irqSrc;
  } reqStrobe_t;
endpackage

// File: rtl/uart_req_ctl.sv
module uart_req_ctl
  import uart_req_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CH_NUM-1:0]     flag,
  input  logic [CH_NUM-1:0]     dmaEn,
  input  logic [CH_NUM-1:0]     irqEn,
  input  logic [CH_NUM-1:0]     dmaAck,
  input  logic [ERR_W-1:0]      rxErr,
  input  logic                  errIrqEn,
  output reqStrobe_t            strb
);
  logic [CH_NUM-1:0] prevFlag;
  logic [CH_NUM-1:0] flagRise;

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
    // previous-value register; tracks the live flag during reset too
    always_ff @(posedge clk) begin
      if (!rst_n) prevFlag[ch] <= flag[ch];
      else        prevFlag[ch] <= flag[ch];
    end

    assign flagRise[ch]    = flag[ch] & ~prevFlag[ch];
    assign strb.setReq[ch] = flagRise[ch] & dmaEn[ch];
    assign strb.clrReq[ch] = dmaAck[ch];
    // DMA on this side overrides the interrupt enable
    assign strb.irqSrc[ch] = flag[ch] & irqEn[ch] & ~dmaEn[ch];
  end

  assign strb.irqSrc[CH_NUM] = (|rxErr) & errIrqEn;
endmodule

// File: rtl/uart_req_dp.sv
module uart_req_dp
  import uart_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  reqStrobe_t        strb,
  output logic [CH_NUM-1:0] dmaReq,
  output logic              irqOut
);
  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_req
    always_ff @(posedge clk) begin
      if (!rst_n)                 dmaReq[ch] <= 1'b0;
      else if (strb.setReq[ch])   dmaReq[ch] <= 1'b1;  // new edge beats ack
      else if (strb.clrReq[ch])   dmaReq[ch] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= |strb.irqSrc;
  end
endmodule

// File: rtl/uart_req_ctrl.sv
module uart_req_ctrl
  import uart_req_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic [ERR_W-1:0] rxErr,
  input  logic             txDmaEn,
  input  logic             rxDmaEn,
  input  logic             txIrqEn,
  input  logic             rxIrqEn,
  input  logic             errIrqEn,
  input  logic             txDmaAck,
  input  logic             rxDmaAck,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             irqOut
);
  reqStrobe_t        strb;
  logic [CH_NUM-1:0] flagVec, dmaEnVec, irqEnVec, ackVec, reqVec;

  assign flagVec[CH_TX]  = txEmpty;
  assign flagVec[CH_RX]  = rxFull;
  assign dmaEnVec[CH_TX] = txDmaEn;
  assign dmaEnVec[CH_RX] = rxDmaEn;
  assign irqEnVec[CH_TX] = txIrqEn;
  assign irqEnVec[CH_RX] = rxIrqEn;
  assign ackVec[CH_TX]   = txDmaAck;
  assign ackVec[CH_RX]   = rxDmaAck;

  uart_req_ctl #(.ERR_W(ERR_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag     (flagVec),
    .dmaEn    (dmaEnVec),
    .irqEn    (irqEnVec),
    .dmaAck   (ackVec),
    .rxErr    (rxErr),
    .errIrqEn (errIrqEn),
    .strb     (strb)
  );

  uart_req_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .dmaReq (reqVec),
    .irqOut (irqOut)
  );

  assign txDmaReq = reqVec[CH_TX];
  assign rxDmaReq = reqVec[CH_RX];
endmodule

// File: rtl/uart_req_chk.sv
module uart_req_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txEmpty,
  input logic             rxFull,
  input logic [ERR_W-1:0] rxErr,
  input logic             txDmaEn,
  input logic             rxDmaEn,
  input logic             txIrqEn,
  input logic             rxIrqEn,
  input logic             errIrqEn,
  input logic             txDmaAck,
  input logic             rxDmaAck,
  input logic             txDmaReq,
  input logic             rxDmaReq,
  input logic             irqOut
);
  a_r1_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (txDmaEn && txEmpty && !$past(txEmpty)) |=> txDmaReq);

  a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDmaEn && rxFull && !$past(rxFull)) |=> rxDmaReq);

  a_r3_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txDmaReq) |-> $past(txDmaEn && txEmpty));

  a_r4_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (txDmaAck && !(txDmaEn && txEmpty && !$past(txEmpty))) |=> !txDmaReq);

  a_r4_rx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDmaAck && !(rxDmaEn && rxFull && !$past(rxFull))) |=> !rxDmaReq);

  a_r6_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (txDmaEn && !(rxFull && rxIrqEn && !rxDmaEn) && !((|rxErr) && errIrqEn))
      |=> !irqOut);

  a_r7_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDmaEn && !(txEmpty && txIrqEn && !txDmaEn) && !((|rxErr) && errIrqEn))
      |=> !irqOut);

  a_r8_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rxErr) && errIrqEn) |=> irqOut);

  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> (!txDmaReq && !rxDmaReq && !irqOut));
endmodule

bind uart_req_ctrl uart_req_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txEmpty(txEmpty), .rxFull(rxFull), .rxErr(rxErr),
  .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn), .txIrqEn(txIrqEn), .rxIrqEn(rxIrqEn),
  .errIrqEn(errIrqEn), .txDmaAck(txDmaAck), .rxDmaAck(rxDmaAck),
  .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irqOut(irqOut)
);

// File: tb/uart_req_ctrl_bench.sv
module uart_req_ctrl_bench;
  localparam int ERR_W  = 3;
  localparam int NV     = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txEmpty = 1'b0, rxFull = 1'b0;
  logic [ERR_W-1:0] rxErr = '0;
  logic txDmaEn = 1'b0, rxDmaEn = 1'b0, txIrqEn = 1'b0, rxIrqEn = 1'b0, errIrqEn = 1'b0;
  logic txDmaAck = 1'b0, rxDmaAck = 1'b0;
  logic txDmaReq, rxDmaReq, irqOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_req_ctrl #(.ERR_W(ERR_W)) u_uart_req_ctrl (
    .clk(clk), .rst_n(rst_n), .txEmpty(txEmpty), .rxFull(rxFull), .rxErr(rxErr),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn), .txIrqEn(txIrqEn), .rxIrqEn(rxIrqEn),
    .errIrqEn(errIrqEn), .txDmaAck(txDmaAck), .rxDmaAck(rxDmaAck),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irqOut(irqOut)
  );

  // {txE, rxF, err[2:0], txDE, rxDE, txIE, rxIE, eIE, txAck, rxAck, expTx, expRx, expIrq}
  localparam logic [14:0] VEC [NV] = '{
    15'b1_0_000_0_0_1_0_0_0_0_0_0_1,  // 1  R9 tx irq unmasked
    15'b1_0_000_1_0_1_0_0_0_0_0_0_0,  // 2  R6 masked, R3 flag already set
    15'b0_0_000_1_0_1_0_0_0_0_0_0_0,  // 3  R1 flag clears
    15'b1_0_000_1_0_1_0_0_0_0_1_0_0,  // 4  R1 rise -> request
    15'b1_0_000_1_0_1_0_0_0_0_1_0_0,  // 5  R4 holds
    15'b1_0_000_1_0_1_0_0_1_0_0_0_0,  // 6  R4 ack clears
    15'b1_1_000_1_0_1_1_0_0_0_0_0_1,  // 7  R9 rx irq unmasked
    15'b1_1_000_1_1_1_1_0_0_0_0_0_0,  // 8  R7 masked, R3 no edge
    15'b1_0_000_1_1_1_1_0_0_0_0_0_0,  // 9  R2 flag clears
    15'b0_1_000_1_1_1_1_0_0_0_0_1_0,  // 10 R2 rise -> request
    15'b0_1_010_1_1_1_1_1_0_0_0_1_1,  // 11 R8 error irq under DMA
    15'b0_1_010_1_1_1_1_0_0_0_0_1_0,  // 12 R8 error masked by enable
    15'b1_1_000_1_1_1_1_0_0_1_1_0_0,  // 13 R1 tx rise, R4 rx ack
    15'b0_0_000_1_1_1_1_0_1_0_0_0_0,  // 14 R4 tx ack
    15'b1_1_000_1_1_1_1_0_0_0_1_1_0,  // 15 R1 R2 both rise together
    15'b1_1_000_1_1_1_1_0_1_1_0_0_0,  // 16 R4 both ack together
    15'b1_1_000_1_1_1_1_0_1_1_0_0_0,  // 17 R5 ack while low
    15'b0_1_000_0_0_0_0_0_0_0_0_0_0,  // 18 R9 no sources
    15'b1_1_000_0_0_0_0_0_0_0_0_0_0   // 19 R3 rise with DMA off
  };
  localparam int VREQ [NV] = '{9, 6, 1, 1, 4, 4, 9, 7, 2, 2, 8, 8, 1, 4, 1, 4, 5, 9, 3};

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: {txReq,rxReq,irq} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic setCtl(input logic tE, input logic rF, input logic [ERR_W-1:0] er,
                        input logic tDE, input logic rDE, input logic tIE, input logic rIE,
                        input logic eIE, input logic tA, input logic rA);
    txEmpty = tE; rxFull = rF; rxErr = er;
    txDmaEn = tDE; rxDmaEn = rDE; txIrqEn = tIE; rxIrqEn = rIE; errIrqEn = eIE;
    txDmaAck = tA; rxDmaAck = rA;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    // R10: reset with tx flag already set and tx DMA enabled
    setCtl(1, 0, '0, 1, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset state", {txDmaReq, rxDmaReq, irqOut}, 3'b000);
    rst_n = 1'b1;
    step();
    check("R10 no request after reset", {txDmaReq, rxDmaReq, irqOut}, 3'b000);
    step();
    check("R3 flag held set", {txDmaReq, rxDmaReq, irqOut}, 3'b000);

    setCtl(0, 0, '0, 0, 0, 0, 0, 0, 0, 0);
    step();

    for (int i = 0; i < NV; i++) begin
      setCtl(VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9], VEC[i][8], VEC[i][7],
             VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      step();
      check($sformatf("R%0d vector %0d", VREQ[i], i + 1),
            {txDmaReq, rxDmaReq, irqOut}, VEC[i][2:0]);
    end

    // R5: ack and a new edge in the same cycle
    setCtl(0, 1, '0, 1, 0, 0, 0, 0, 0, 0);
    step();
    setCtl(1, 1, '0, 1, 0, 0, 0, 0, 0, 0);
    step();
    check("R1 directed rise", {txDmaReq, rxDmaReq, irqOut}, 3'b100);
    setCtl(0, 1, '0, 1, 0, 0, 0, 0, 0, 0);
    step();
    check("R4 pending hold", {txDmaReq, rxDmaReq, irqOut}, 3'b100);
    setCtl(1, 1, '0, 1, 0, 0, 0, 0, 1, 0);
    step();
    check("R5 edge beats ack", {txDmaReq, rxDmaReq, irqOut}, 3'b100);
    setCtl(1, 1, '0, 1, 0, 0, 0, 0, 1, 0);
    step();
    check("R4 plain ack", {txDmaReq, rxDmaReq, irqOut}, 3'b000);

    // R10: reset while a request is pending
    setCtl(0, 1, '0, 1, 0, 0, 0, 0, 0, 0);
    step();
    setCtl(1, 1, '0, 1, 0, 0, 0, 0, 0, 0);
    step();
    check("R1 rise before reset", {txDmaReq, rxDmaReq, irqOut}, 3'b100);
    rst_n = 1'b0;
    step();
    check("R10 reset clears request", {txDmaReq, rxDmaReq, irqOut}, 3'b000);
    rst_n = 1'b1;
    step();
    check("R10 stays clear", {txDmaReq, rxDmaReq, irqOut}, 3'b000);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule